// File: doc/BRIEF.md
# CPU Bus Cycle Dispatcher

The dispatcher sits between the processor's bus-status decode and the memory and expansion-bus machinery. At the start of every processor bus cycle it samples the cycle kind and the region attributes of the address, and sends the cycle to exactly one place. The expansion bus gets memory and I/O accesses that miss local DRAM, and all ROM accesses. Local DRAM gets accesses to DRAM and to write-protected shadow regions. Interrupt acknowledge, halt and shutdown cycles are finished inside the block with a ready pulse. The block drives no address or command timing itself. It raises an address-latch request, holds a command enable until the bus timing logic reports completion, and then returns ready.

External logic may take over expansion-bus cycles when a claim mode is enabled. In that case the block spends one extra clock in a claim window and samples the claim input at the end of it. An unclaimed cycle then proceeds one clock later than it would without the mode. A claimed cycle is dropped silently. Writes to ROM regions become ordinary expansion-bus memory writes with the ROM select left inactive. Writes to protected shadow RAM keep DRAM timing with the column strobe held off.

Top module: `cyc_dispatch`

## Requirements
- R1: After reset and while idle the outputs are: xbus_ale=0, xbus_cmd=0, rom_cs_n=1, cas_en=0, cpu_rdy=0, cpu_rst_req=0, dir_lo=1, dir_hi=1, vec_out=0.
- R2: Cycle kind encoding on cyc_kind is: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge, 5 halt, 6 shutdown. Take an expansion-bus cycle with claim_en=0 whose status edge (ts_vld=1) is clock edge E. xbus_ale is high for the single cycle after E. xbus_cmd is high from the next cycle until the edge at which bus_done is sampled high. cpu_rdy is high for the one cycle after that edge.
- R3: With claim_en=1 and ext_claim low at the edge after E, the expansion-bus cycle of R2 runs one clock later: xbus_ale is high in the second cycle after E.
- R4: With claim_en=1 and ext_claim high at the edge after E, the cycle produces no xbus_ale, no xbus_cmd and no cpu_rdy.
- R5: An interrupt acknowledge produces no xbus_ale and no xbus_cmd. cpu_rdy is high for the one cycle after E, and in that cycle vec_out equals vec_in as sampled at E. vec_out is zero in every other cycle.
- R6: A halt cycle produces only a one-cycle cpu_rdy pulse in the cycle after E.
- R7: A shutdown cycle raises cpu_rdy and cpu_rst_req together for the one cycle after E.
- R8: A memory read with rom_hit=1 goes to the expansion bus even when dram_hit=1, and rom_cs_n is low in its ale and command cycles.
- R9: A memory write with rom_hit=1 is an expansion-bus cycle with xbus_cmd asserted and rom_cs_n held high throughout.
- R10: A memory access with wp_hit=1 or dram_hit=1 (and rom_hit=0) goes to DRAM. cas_en is high for the one cycle after E and cpu_rdy is high in the following cycle. For a write with wp_hit=1, cas_en stays low. DRAM cycles never open a claim window.
- R11: dir_lo and dir_hi are equal. Both are low only during command cycles of expansion-bus reads (kinds 0 and 2), and high otherwise.
- R12: ts_vld is ignored while a cycle is in progress, and a status with cyc_kind=7 starts no cycle.
- R13: In no cycle is cas_en high together with xbus_ale or xbus_cmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_vld | input | 1 | High on the edge that samples the cycle status |
| cyc_kind | input | 3 | Cycle kind code (see R2) |
| rom_hit | input | 1 | Address falls in a ROM region |
| wp_hit | input | 1 | Address falls in write-protected shadow RAM |
| dram_hit | input | 1 | Address falls in local DRAM |
| claim_en | input | 1 | Claim mode enabled for expansion-bus cycles |
| ext_claim | input | 1 | External logic claims the pending cycle |
| bus_done | input | 1 | Expansion-bus command phase finished |
| vec_in | input | VEC_W | Interrupt vector from the interrupt controller |
| xbus_ale | output | 1 | Expansion-bus start with address-latch request |
| xbus_cmd | output | 1 | Expansion-bus command enable |
| rom_cs_n | output | 1 | ROM chip select, active low |
| cas_en | output | 1 | DRAM column strobe enable |
| cpu_rdy | output | 1 | Ready to the processor |
| cpu_rst_req | output | 1 | Processor reset request |
| dir_lo | output | 1 | Low-byte data direction, high = idle/write |
| dir_hi | output | 1 | High-byte data direction, high = idle/write |
| vec_out | output | VEC_W | Vector returned with acknowledge ready |

## Verification
Ready and reset request fall in the same cycle on a shutdown. A scoreboard entry expects both high together and both low on the next cycle, so a design that lags one of them by a clock, or keeps it high, shows a mismatch. Ready and the vector output also coincide on an interrupt acknowledge. This case is provoked with a distinctive vector and with vec_in changed right after the status edge, so the entry is judged on a latched value. A fresh status is also driven in the middle of a bus command phase, and the bench expects the command and ready timing of the running cycle to stay untouched.

// File: rtl/cyc_dispatch_pkg.sv
package cyc_dispatch_pkg;

    typedef enum logic [2:0] {
        K_MEM_RD = 3'd0,
        K_MEM_WR = 3'd1,
        K_IO_RD  = 3'd2,
        K_IO_WR  = 3'd3,
        K_INTA   = 3'd4,
        K_HALT   = 3'd5,
        K_SHUT   = 3'd6,
        K_NONE   = 3'd7
    } kind_t;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_BUS  = 2'd1,
        DST_DRAM = 2'd2,
        DST_INT  = 2'd3
    } dest_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CLAIM = 3'd1,
        S_ALE   = 3'd2,
        S_CMD   = 3'd3,
        S_DRAM  = 3'd4
    } state_t;

    typedef struct packed {
        dest_t dest;
        logic  rd;
        logic  rom_rd;
        logic  cas_ok;
        logic  inta;
        logic  shut;
    } cls_t;

endpackage

// File: rtl/cyc_classify.sv
module cyc_classify
    import cyc_dispatch_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       rom_hit,
    input  logic       wp_hit,
    input  logic       dram_hit,
    output cls_t       cls
);

    kind_t k;
    assign k = kind_t'(kind);

    always_comb begin
        cls      = '0;
        cls.dest = DST_NONE;
        case (k)
            K_MEM_RD: begin
                cls.rd = 1'b1;
                if (rom_hit) begin
                    cls.dest   = DST_BUS;
                    cls.rom_rd = 1'b1;
                end else if (wp_hit || dram_hit) begin
                    cls.dest   = DST_DRAM;
                    cls.cas_ok = 1'b1;
                end else begin
                    cls.dest = DST_BUS;
                end
            end
            K_MEM_WR: begin
                if (rom_hit) begin
                    cls.dest = DST_BUS;
                end else if (wp_hit) begin
                    cls.dest   = DST_DRAM;
                    cls.cas_ok = 1'b0;
                end else if (dram_hit) begin
                    cls.dest   = DST_DRAM;
                    cls.cas_ok = 1'b1;
                end else begin
                    cls.dest = DST_BUS;
                end
            end
            K_IO_RD: begin
                cls.dest = DST_BUS;
                cls.rd   = 1'b1;
            end
            K_IO_WR: cls.dest = DST_BUS;
            K_INTA: begin
                cls.dest = DST_INT;
                cls.inta = 1'b1;
            end
            K_HALT: cls.dest = DST_INT;
            K_SHUT: begin
                cls.dest = DST_INT;
                cls.shut = 1'b1;
            end
            default: cls.dest = DST_NONE;
        endcase
    end

endmodule

// File: rtl/cyc_sequencer.sv
module cyc_sequencer
    import cyc_dispatch_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_vld,
    input  cls_t             cls_in,
    input  logic             claim_en,
    input  logic             ext_claim,
    input  logic             bus_done,
    input  logic [VEC_W-1:0] vec_in,
    output logic             ale,
    output logic             cmd,
    output logic             rom_cs_n,
    output logic             cas_en,
    output logic             rdy,
    output logic             rst_req,
    output logic             dir_lo,
    output logic             dir_hi,
    output logic [VEC_W-1:0] vec_out
);

    typedef struct packed {
        state_t           st;
        cls_t             cls;
        logic             ale;
        logic             cmd;
        logic             rom_cs_n;
        logic             cas;
        logic             rdy;
        logic             rst_req;
        logic             dir;
        logic [VEC_W-1:0] vec;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:       S_IDLE,
        cls:      '0,
        ale:      1'b0,
        cmd:      1'b0,
        rom_cs_n: 1'b1,
        cas:      1'b0,
        rdy:      1'b0,
        rst_req:  1'b0,
        dir:      1'b1,
        vec:      '0
    };

    seq_t seq_d, seq_q;
    logic in_bus;

    always_comb begin
        seq_d         = seq_q;
        seq_d.rdy     = 1'b0;
        seq_d.rst_req = 1'b0;
        seq_d.vec     = '0;

        case (seq_q.st)
            S_IDLE: begin
                if (ts_vld && cls_in.dest != DST_NONE) begin
                    seq_d.cls = cls_in;
                    case (cls_in.dest)
                        DST_BUS:  seq_d.st = claim_en ? S_CLAIM : S_ALE;
                        DST_DRAM: seq_d.st = S_DRAM;
                        default: begin
                            seq_d.rdy     = 1'b1;
                            seq_d.rst_req = cls_in.shut;
                            seq_d.vec     = cls_in.inta ? vec_in : '0;
                        end
                    endcase
                end
            end
            S_CLAIM: seq_d.st = ext_claim ? S_IDLE : S_ALE;
            S_ALE:   seq_d.st = S_CMD;
            S_CMD: begin
                if (bus_done) begin
                    seq_d.st  = S_IDLE;
                    seq_d.rdy = 1'b1;
                end
            end
            S_DRAM: begin
                seq_d.st  = S_IDLE;
                seq_d.rdy = 1'b1;
            end
            default: seq_d.st = S_IDLE;
        endcase

        in_bus         = (seq_d.st == S_ALE) || (seq_d.st == S_CMD);
        seq_d.ale      = (seq_d.st == S_ALE);
        seq_d.cmd      = (seq_d.st == S_CMD);
        seq_d.rom_cs_n = !(in_bus && seq_d.cls.rom_rd);
        seq_d.cas      = (seq_d.st == S_DRAM) && seq_d.cls.cas_ok;
        seq_d.dir      = !((seq_d.st == S_CMD) && seq_d.cls.rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ale      = seq_q.ale;
    assign cmd      = seq_q.cmd;
    assign rom_cs_n = seq_q.rom_cs_n;
    assign cas_en   = seq_q.cas;
    assign rdy      = seq_q.rdy;
    assign rst_req  = seq_q.rst_req;
    assign dir_lo   = seq_q.dir;
    assign dir_hi   = seq_q.dir;
    assign vec_out  = seq_q.vec;

endmodule

// File: rtl/cyc_dispatch.sv
module cyc_dispatch
    import cyc_dispatch_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_vld,
    input  logic [2:0]       cyc_kind,
    input  logic             rom_hit,
    input  logic             wp_hit,
    input  logic             dram_hit,
    input  logic             claim_en,
    input  logic             ext_claim,
    input  logic             bus_done,
    input  logic [VEC_W-1:0] vec_in,
    output logic             xbus_ale,
    output logic             xbus_cmd,
    output logic             rom_cs_n,
    output logic             cas_en,
    output logic             cpu_rdy,
    output logic             cpu_rst_req,
    output logic             dir_lo,
    output logic             dir_hi,
    output logic [VEC_W-1:0] vec_out
);

    cls_t cls_w;

    cyc_classify u_cls (
        .kind     (cyc_kind),
        .rom_hit  (rom_hit),
        .wp_hit   (wp_hit),
        .dram_hit (dram_hit),
        .cls      (cls_w)
    );

    cyc_sequencer #(.VEC_W(VEC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ts_vld    (ts_vld),
        .cls_in    (cls_w),
        .claim_en  (claim_en),
        .ext_claim (ext_claim),
        .bus_done  (bus_done),
        .vec_in    (vec_in),
        .ale       (xbus_ale),
        .cmd       (xbus_cmd),
        .rom_cs_n  (rom_cs_n),
        .cas_en    (cas_en),
        .rdy       (cpu_rdy),
        .rst_req   (cpu_rst_req),
        .dir_lo    (dir_lo),
        .dir_hi    (dir_hi),
        .vec_out   (vec_out)
    );

endmodule

// File: rtl/cyc_dispatch_chk.sv
module cyc_dispatch_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ts_vld,
    input logic [2:0]       cyc_kind,
    input logic             rom_hit,
    input logic             wp_hit,
    input logic             dram_hit,
    input logic             claim_en,
    input logic             ext_claim,
    input logic             bus_done,
    input logic [VEC_W-1:0] vec_in,
    input logic             xbus_ale,
    input logic             xbus_cmd,
    input logic             rom_cs_n,
    input logic             cas_en,
    input logic             cpu_rdy,
    input logic             cpu_rst_req,
    input logic             dir_lo,
    input logic             dir_hi,
    input logic [VEC_W-1:0] vec_out
);

    p_ale_then_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_ale |=> xbus_cmd);

    p_cmd_done_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_cmd && bus_done) |=> (cpu_rdy && !xbus_cmd));

    p_noclaim_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_ale && !claim_en) |-> $past(ts_vld));

    p_claim_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_ale && claim_en) |-> !$past(ts_vld));

    p_vec_with_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_out != '0) |-> (cpu_rdy && !xbus_cmd));

    p_rst_with_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_req |-> cpu_rdy);

    p_rom_cs_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> !(xbus_cmd && dir_lo));

    p_one_dest_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cas_en |-> (!xbus_ale && !xbus_cmd));

    always @(posedge clk) begin
        if (rst_n) begin
            p_dir_pair_r11: assert (dir_lo == dir_hi);
        end
    end

endmodule

bind cyc_dispatch cyc_dispatch_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/cyc_dispatch_test.sv
`timescale 1ns/1ps
module cyc_dispatch_test;

    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ts_vld = 1'b0;
    logic [2:0]    cyc_kind = 3'd7;
    logic          rom_hit = 1'b0, wp_hit = 1'b0, dram_hit = 1'b0;
    logic          claim_en = 1'b0, ext_claim = 1'b0, bus_done = 1'b0;
    logic [VW-1:0] vec_in = '0;
    logic          xbus_ale, xbus_cmd, rom_cs_n, cas_en, cpu_rdy, cpu_rst_req, dir_lo, dir_hi;
    logic [VW-1:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    localparam logic [15:0] IDLE_V = {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00};

    always #4 clk = ~clk;

    cyc_dispatch #(.VEC_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .ts_vld(ts_vld), .cyc_kind(cyc_kind),
        .rom_hit(rom_hit), .wp_hit(wp_hit), .dram_hit(dram_hit),
        .claim_en(claim_en), .ext_claim(ext_claim), .bus_done(bus_done),
        .vec_in(vec_in), .xbus_ale(xbus_ale), .xbus_cmd(xbus_cmd),
        .rom_cs_n(rom_cs_n), .cas_en(cas_en), .cpu_rdy(cpu_rdy),
        .cpu_rst_req(cpu_rst_req), .dir_lo(dir_lo), .dir_hi(dir_hi),
        .vec_out(vec_out)
    );

    function automatic logic [15:0] observed();
        return {xbus_ale, xbus_cmd, rom_cs_n, cas_en, cpu_rdy, cpu_rst_req, dir_lo, dir_hi, vec_out};
    endfunction

    function automatic logic [15:0] mk(input logic ale, input logic cmd, input logic romn,
                                       input logic cas, input logic rdy, input logic rst,
                                       input logic dir, input logic [7:0] v);
        return {ale, cmd, romn, cas, rdy, rst, dir, dir, v};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (ale,cmd,romn,cas,rdy,rst,dlo,dhi,vec)", tag, act, exp);
        end
    endtask

    // Monitor: compares one expected vector per cycle, sampled 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() != 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, observed(), e);
            end
        end
    end

    task automatic push(input string tag, input logic [15:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Driver: one processor cycle with its full expected output trace
    task automatic run_cyc(input string tag, input logic [2:0] kind, input logic rom,
                           input logic wp, input logic dram, input logic cen,
                           input logic claim, input int waitn, input logic [7:0] vec,
                           input logic intrude);
        bit is_mem, is_bus, is_dram, rd, romrd;
        int base, len;
        is_mem  = (kind == 3'd0) || (kind == 3'd1);
        rd      = (kind == 3'd0) || (kind == 3'd2);
        romrd   = (kind == 3'd0) && rom;
        is_dram = is_mem && !rom && (wp || dram);
        is_bus  = (kind <= 3'd3) && !is_dram;
        base    = (is_bus && cen) ? 1 : 0;

        @(negedge clk);
        ts_vld = 1'b1; cyc_kind = kind; rom_hit = rom; wp_hit = wp; dram_hit = dram;
        claim_en = cen; vec_in = vec;

        if (is_bus) begin
            if (cen) push(tag, IDLE_V);
            if (cen && claim) begin
                push(tag, IDLE_V);
                push(tag, IDLE_V);
            end else begin
                push(tag, mk(1, 0, !romrd, 0, 0, 0, 1, 8'h00));
                for (int w = 0; w < waitn; w++) push(tag, mk(0, 1, !romrd, 0, 0, 0, !rd, 8'h00));
                push(tag, mk(0, 0, 1, 0, 1, 0, 1, 8'h00));
                push(tag, IDLE_V);
            end
        end else if (is_dram) begin
            push(tag, mk(0, 0, 1, !(wp && kind == 3'd1), 0, 0, 1, 8'h00));
            push(tag, mk(0, 0, 1, 0, 1, 0, 1, 8'h00));
            push(tag, IDLE_V);
        end else if (kind >= 3'd4 && kind <= 3'd6) begin
            push(tag, mk(0, 0, 1, 0, 1, kind == 3'd6, 1, (kind == 3'd4) ? vec : 8'h00));
            push(tag, IDLE_V);
        end else begin
            push(tag, IDLE_V);
            push(tag, IDLE_V);
        end
        len = exp_q.size();

        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            ts_vld    = intrude && is_bus && (i == base + 2);
            cyc_kind  = ts_vld ? 3'd6 : 3'd7;
            vec_in    = 8'h00;
            ext_claim = (i == 1) && cen && claim;
            bus_done  = is_bus && (i == base + waitn + 1);
        end
        ts_vld = 1'b0; ext_claim = 1'b0; bus_done = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", observed(), IDLE_V);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", observed(), IDLE_V);

        run_cyc("R2 io read, R11 dir low",  3'd2, 0, 0, 0, 0, 0, 2, 8'h00, 0);
        run_cyc("R2 io write single wait",  3'd3, 0, 0, 0, 0, 0, 1, 8'h00, 0);
        run_cyc("R2 mem read miss",         3'd0, 0, 0, 0, 0, 0, 3, 8'h00, 0);
        run_cyc("R8 rom read beats dram",   3'd0, 1, 0, 1, 0, 0, 2, 8'h00, 0);
        run_cyc("R9 rom write on bus",      3'd1, 1, 0, 1, 0, 0, 2, 8'h00, 0);
        run_cyc("R10 wp write no cas",      3'd1, 0, 1, 0, 0, 0, 0, 8'h00, 0);
        run_cyc("R10 dram write cas",       3'd1, 0, 0, 1, 0, 0, 0, 8'h00, 0);
        run_cyc("R10 wp read cas",          3'd0, 0, 1, 0, 0, 0, 0, 8'h00, 0);
        run_cyc("R5 inta vector",           3'd4, 0, 0, 0, 0, 0, 0, 8'hA5, 0);
        run_cyc("R6 halt ready only",       3'd5, 0, 0, 0, 0, 0, 0, 8'h3C, 0);
        run_cyc("R7 shutdown rdy+rst",      3'd6, 0, 0, 0, 0, 0, 0, 8'h00, 0);
        run_cyc("R3 claim window unclaimed", 3'd2, 0, 0, 0, 1, 0, 2, 8'h00, 0);
        run_cyc("R3 claim rom read",        3'd0, 1, 0, 0, 1, 0, 1, 8'h00, 0);
        run_cyc("R4 claimed cycle dropped", 3'd3, 0, 0, 0, 1, 1, 1, 8'h00, 0);
        run_cyc("R10 dram no claim window", 3'd0, 0, 0, 1, 1, 0, 0, 8'h00, 0);
        run_cyc("R5 inta with claim mode",  3'd4, 0, 0, 0, 1, 0, 0, 8'h5A, 0);
        run_cyc("R12 status while busy",    3'd2, 0, 0, 0, 0, 0, 3, 8'h00, 1);
        run_cyc("R12 kind 7 ignored",       3'd7, 1, 1, 1, 0, 0, 0, 8'hFF, 0);
        run_cyc("R13 write after claim",    3'd1, 0, 0, 0, 1, 0, 2, 8'h00, 0);

        repeat (2) @(negedge clk);
        check("R1 idle at end", observed(), IDLE_V);

        done_flag = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule